// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets on-chip logic read or write one byte at a time in an external asynchronous static RAM. That RAM has a 19-bit address, an 8-bit data bus and two chip selects of opposite polarity. Requests arrive on a valid/ready channel that carries a direction flag, an address and write data. Read results come back on a response channel as a registered byte with a one-cycle valid strobe.

On the memory side the block drives the address, both chip selects, an active-low output enable and an active-low write enable. The data bus is split into an output byte, an output-enable for the pad driver and an input byte, and the pad ring joins them into the bidirectional pins. Every phase of an access lasts a whole number of clocks. These counts are derived at elaboration from nanosecond limits and the clock period: each count is the nanoseconds divided by the period, rounded up, and never less than one. Writes are controlled by the write enable, with the output enable held inactive throughout. Every access ends in a turnaround phase with the memory deselected, which gives the memory time to release the bus.

Back-pressure rules: a request transfers on a rising edge where both `req_valid` and `req_ready` are high. While `req_ready` is low, the requester must hold the request. The block holds one access at a time and never stalls the response channel. `rsp_valid` is a pulse and must be taken in the cycle it appears.

Top module: `sram_ctl`

## Requirements
- R1: During and right after reset, both chip selects are inactive (`mem_ce_n`=1, `mem_ce`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: A request is taken only on an edge where `req_ready` is high. A request that is held while `req_ready` is low starts no memory activity until it is accepted.
- R3: A read selects the chip with `mem_we_n`=1 and `mem_oe_n`=0 for exactly RD_CYC cycles. The byte on `mem_dq_in` is captured at the end of the last of these cycles. It appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, which is the first cycle after the access.
- R4: A write selects the chip for a setup of SU_CYC cycles with `mem_we_n`=1. Then `mem_we_n`=0 for WP_CYC cycles, and then a hold of HD_CYC cycles with `mem_we_n`=1 while the chip is still selected. The byte stored is the requested write data at the requested address.
- R5: `mem_oe_n` stays 1 for the whole of a write. `mem_dq_oe` is high only in a cycle where `mem_oe_n` is 1 and was also 1 in the cycle before.
- R6: `mem_dq_oe` is high in exactly the setup, pulse and hold cycles of a write, which is SU_CYC+WP_CYC+HD_CYC cycles. `mem_dq_out` is constant while it is high.
- R7: After each access there are TA_CYC turnaround cycles with both chip selects inactive, `mem_oe_n`=1 and `mem_dq_oe`=0. `req_ready` returns high in the cycle after the turnaround.
- R8: `mem_addr` stays equal to the accepted address for as long as the chip is selected.
- R9: The cycle counts are derived as ceil(ns/CLK_NS), with a minimum of 1. RD_CYC covers the larger of address access and output-enable access. WP_CYC is at least the write-pulse count, and setup plus pulse covers both the data-setup and address-to-end-of-write limits. TA_CYC covers bus release, write recovery and the shortfall against the minimum read and write cycle times. At 10 ns with the default limits: RD_CYC=10, SU_CYC=1, WP_CYC=5, HD_CYC=1, TA_CYC=4.
- R10: A write never raises `rsp_valid`.
- R11: Reads and writes to different addresses can follow one another in any order, and each read returns the byte most recently written to its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle strobe: read byte valid |
| rsp_rdata | output | 8 | Registered read byte |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Byte for the data-pad drivers |
| mem_dq_oe | output | 1 | Data-pad driver enable |
| mem_dq_in | input | 8 | Byte received from the data pads |

## Verification
The bench uses the default parameters: a 10 ns clock with the slower grade's limits, which give RD_CYC=10, SU_CYC=1, WP_CYC=5, HD_CYC=1 and TA_CYC=4. The read-access window is long enough that the memory model can return a garbage byte until the full access count has elapsed. A read that ends even one cycle early is therefore caught through its data. With a write pulse of several cycles, a turnaround longer than one cycle and a one-cycle setup, every phase boundary is visible, and the bench checks each count by watching the pins. The model also flags any cycle in which the controller drives the bus while the memory could be driving it.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_TURN
  } state_t;

  // Per-state pin intent, registered by the top so the pins come from flops.
  typedef struct packed {
    logic sel;     // both chip selects active
    logic rd_en;   // output enable asserted
    logic wr_en;   // write enable asserted
    logic drive;   // pad drivers on
  } pins_t;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic pins_t decode(input state_t s);
    pins_t p;
    p = '0;
    case (s)
      ST_READ:   begin p.sel = 1'b1; p.rd_en = 1'b1; end
      ST_WSETUP: begin p.sel = 1'b1; p.drive = 1'b1; end
      ST_WPULSE: begin p.sel = 1'b1; p.wr_en = 1'b1; p.drive = 1'b1; end
      ST_WHOLD:  begin p.sel = 1'b1; p.drive = 1'b1; end
      default:   p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= mem_dq_in;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_valid  = rvalid_q;
  assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW       = 19,
  parameter int DW       = 8,
  parameter int CLK_NS   = 10,
  parameter int T_AA_NS  = 100,  // address to data
  parameter int T_OE_NS  = 40,   // output enable to data
  parameter int T_RC_NS  = 100,  // minimum read cycle
  parameter int T_WC_NS  = 100,  // minimum write cycle
  parameter int T_AS_NS  = 0,    // address setup before write enable falls
  parameter int T_WP_NS  = 50,   // write pulse
  parameter int T_AW_NS  = 60,   // address valid to end of write
  parameter int T_DW_NS  = 45,   // data setup to end of write
  parameter int T_DH_NS  = 0,    // data hold after end of write
  parameter int T_WR_NS  = 5,    // write recovery
  parameter int T_HZ_NS  = 35    // memory output release
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int RD_CYC = ns_to_cyc(imax(T_AA_NS, T_OE_NS), CLK_NS);
  localparam int SU_CYC = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int WP_CYC = imax(ns_to_cyc(T_WP_NS, CLK_NS),
                               ns_to_cyc(imax(T_DW_NS, T_AW_NS), CLK_NS) - SU_CYC);
  localparam int HD_CYC = ns_to_cyc(T_DH_NS, CLK_NS);
  localparam int TA_CYC = imax(imax(ns_to_cyc(T_HZ_NS, CLK_NS), ns_to_cyc(T_WR_NS, CLK_NS)),
                               imax(ns_to_cyc(T_RC_NS, CLK_NS) - RD_CYC,
                                    ns_to_cyc(T_WC_NS, CLK_NS) - SU_CYC - WP_CYC - HD_CYC));
  localparam int MAX_CYC = imax(imax(RD_CYC, SU_CYC), imax(imax(WP_CYC, HD_CYC), TA_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  state_t           state_q, state_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             last;
  logic             accept;
  logic             capture;
  pins_t            pins_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .last     (last)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    capture  = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        load = 1'b1;
        if (req_write) begin
          state_d  = ST_WSETUP;
          load_val = CNT_W'(SU_CYC - 1);
        end else begin
          state_d  = ST_READ;
          load_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_READ: if (last) begin
        capture  = 1'b1;
        state_d  = ST_TURN;
        load     = 1'b1;
        load_val = CNT_W'(TA_CYC - 1);
      end
      ST_WSETUP: if (last) begin
        state_d  = ST_WPULSE;
        load     = 1'b1;
        load_val = CNT_W'(WP_CYC - 1);
      end
      ST_WPULSE: if (last) begin
        state_d  = ST_WHOLD;
        load     = 1'b1;
        load_val = CNT_W'(HD_CYC - 1);
      end
      ST_WHOLD: if (last) begin
        state_d  = ST_TURN;
        load     = 1'b1;
        load_val = CNT_W'(TA_CYC - 1);
      end
      ST_TURN: if (last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pins_q  <= '0;
    end else begin
      state_q <= state_d;
      pins_q  <= decode(state_d);
    end
  end

  sram_ctl_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture    (capture),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  assign mem_ce_n  = ~pins_q.sel;
  assign mem_ce    =  pins_q.sel;
  assign mem_oe_n  = ~pins_q.rd_en;
  assign mem_we_n  = ~pins_q.wr_en;
  assign mem_dq_oe =  pins_q.drive;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_ce,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  p_we_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_ce && mem_oe_n && mem_dq_oe));

  p_drive_after_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

  p_wdata_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce && mem_oe_n && !mem_dq_oe));

  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_no_rsp_in_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !rsp_valid);
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_ce     (mem_ce),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_ctl_test.sv
module sram_ctl_test;
  localparam int RD = 10, SU = 1, WP = 5, HD = 1, TA = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'h5A;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sram_ctl uut (.*);

  // Memory model, evaluated at falling edges when the pins are settled.
  logic [7:0]  mem [int];
  int          rdcnt = 0;
  logic        we_prev = 1'b1;
  logic [18:0] addr_prev = '0;

  always @(negedge clk) begin
    logic rd_cond;
    rd_cond = !mem_ce_n && mem_ce && !mem_oe_n && mem_we_n;
    if (rd_cond && mem_addr == addr_prev) rdcnt = rdcnt + 1;
    else if (rd_cond) rdcnt = 1;
    else rdcnt = 0;
    addr_prev = mem_addr;
    mem_dq_in = (rdcnt >= RD) ? (mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00) : 8'h5A;
    if (rst_n && !we_prev && mem_we_n && !mem_ce_n && mem_ce && mem_dq_oe)
      mem[int'(mem_addr)] = mem_dq_out;
    we_prev = mem_we_n;
    if (rst_n && mem_dq_oe && !mem_oe_n) begin
      checks++; errors++;
      $display("FAIL R5 bus contention: dq_oe=%0b oe_n=%0b expected no overlap", mem_dq_oe, mem_oe_n);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 pins idle in reset",
          {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    check(req_ready && !rsp_valid, "R1 ready/valid in reset", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready, "R1 idle after reset",
          {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 6'b101101);
  endtask

  task automatic t_write(input logic [18:0] a, input logic [7:0] d);
    int we_lo = 0, drv = 0, oe_lo = 0, rsp = 0, first_we = 0, ta_bad = 0, rdy_bad = 0, sel = 0;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~d;
    for (int k = 1; k <= SU + WP + HD + TA + 1; k++) begin
      if (k > 1) @(negedge clk);
      if (!mem_we_n) begin we_lo++; if (first_we == 0) first_we = k; end
      if (mem_dq_oe) begin drv++; if (mem_dq_out != d) ta_bad++; end
      if (!mem_ce_n && mem_ce) sel++;
      if (!mem_oe_n) oe_lo++;
      if (rsp_valid) rsp++;
      if (k > SU + WP + HD && k <= SU + WP + HD + TA && (!mem_ce_n || mem_ce || mem_dq_oe)) ta_bad++;
      if ((k <= SU + WP + HD + TA) == req_ready) rdy_bad++;
    end
    check(we_lo == WP, "R4 R9 write pulse length", we_lo, WP);
    check(first_we == SU + 1, "R4 setup before pulse", first_we, SU + 1);
    check(sel == SU + WP + HD, "R4 select covers setup+pulse+hold", sel, SU + WP + HD);
    check(drv == SU + WP + HD, "R6 driver window", drv, SU + WP + HD);
    check(oe_lo == 0, "R5 output enable held off in write", oe_lo, 0);
    check(rsp == 0, "R10 no response for write", rsp, 0);
    check(ta_bad == 0, "R7 turnaround/data", ta_bad, 0);
    check(rdy_bad == 0, "R7 ready returns after turnaround", rdy_bad, 0);
    check(mem.exists(int'(a)) && mem[int'(a)] == d, "R4 stored byte",
          mem.exists(int'(a)) ? int'(mem[int'(a)]) : -1, d);
  endtask

  task automatic t_read(input logic [18:0] a, input logic [7:0] exp);
    int oe_lo = 0, rsp = 0, rsp_at = 0, ta_bad = 0, addr_bad = 0, rdy_bad = 0;
    logic [7:0] got = '0;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a;
    for (int k = 1; k <= RD + TA + 1; k++) begin
      if (k > 1) @(negedge clk);
      if (!mem_oe_n && !mem_ce_n && mem_ce && mem_we_n) oe_lo++;
      if (rsp_valid) begin rsp++; rsp_at = k; got = rsp_rdata; end
      if (k <= RD && mem_addr != a) addr_bad++;
      if (k > RD && k <= RD + TA && (!mem_ce_n || mem_ce || !mem_oe_n || mem_dq_oe)) ta_bad++;
      if ((k <= RD + TA) == req_ready) rdy_bad++;
    end
    check(oe_lo == RD, "R3 R9 read access length", oe_lo, RD);
    check(rsp == 1 && rsp_at == RD + 1, "R3 single response strobe timing", rsp_at, RD + 1);
    check(got == exp, "R3 R11 read data", got, exp);
    check(addr_bad == 0, "R8 address held during access", addr_bad, 0);
    check(ta_bad == 0, "R7 turnaround after read", ta_bad, 0);
    check(rdy_bad == 0, "R7 ready after read turnaround", rdy_bad, 0);
  endtask

  // A write presented while a read is in flight must wait for ready.
  task automatic t_held_request(input logic [18:0] ra, input logic [18:0] wa, input logic [7:0] d);
    int we_early = 0, waited = 0;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = ra;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = wa; req_wdata = d;
    waited = 3;
    while (!req_ready) begin
      if (!mem_we_n || mem_dq_oe) we_early++;
      if (mem_addr != ra) we_early++;
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(we_early == 0, "R2 held request ignored while busy", we_early, 0);
    check(waited == RD + TA + 1, "R2 accepted on first ready edge", waited, RD + TA + 1);
    repeat (SU + WP + HD + TA + 1) @(negedge clk);
    check(mem.exists(int'(wa)) && mem[int'(wa)] == d, "R2 held write completes",
          mem.exists(int'(wa)) ? int'(mem[int'(wa)]) : -1, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_write(19'h00000, 8'hA3);
    t_write(19'h7FFFF, 8'h3C);
    t_read(19'h00000, 8'hA3);
    t_read(19'h7FFFF, 8'h3C);
    t_read(19'h12345, 8'h00);
    t_write(19'h12345, 8'hFF);
    t_read(19'h12345, 8'hFF);
    t_write(19'h00000, 8'h01);   // R11 overwrite then read back
    t_read(19'h00000, 8'h01);
    t_held_request(19'h7FFFF, 19'h2AAAA, 8'h96);
    t_read(19'h2AAAA, 8'h96);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule